// File: doc/BRIEF.md
# Relative-Addressed Operand Stack for a Floating-Point Unit

This block keeps the working operands of a numeric coprocessor in eight 80-bit slots. Software never names a slot directly. It names a distance from the current top: st(0) is the most recently pushed operand and st(7) is the oldest slot the stack can hold. A three-bit top pointer moves on every push and pop, and each physical slot carries an occupied tag. The tags detect a push onto a full stack (overflow) and any use of an empty slot (underflow). When a fault is detected the stack is left unchanged.

The operand port accepts one command per cycle: push, pop, or swap of st(0) with st(i). Two read paths are always available, st(0) and st(readIdx), so a two-operand arithmetic unit can use st(0) with st(1) or with any named slot. That unit returns its result on a separate write port. The result can overwrite st(i), or it can overwrite st(i) and then pop, which removes the consumed operand. When an operand-port command and a result arrive in the same cycle, the command is applied first. The result is parked for one cycle and then written to the slot it named on arrival.

Top module: `fpStack`

## Requirements
- R1: After reset all eight occupancy bits read 0, `overflow` and `underflow` are 0, and `readUnderflow` is 1.
- R2: Push (`opCode` = 2'd1) makes `pushData` the new st(0), and every older operand moves one position deeper.
- R3: A push while st(7) is occupied changes nothing and raises `overflow` for the one cycle after that edge.
- R4: Pop (`opCode` = 2'd2) removes st(0), and every remaining operand moves one position shallower. The popped value is on `st0Data` in the cycle the pop is presented.
- R5: A pop of an empty st(0), or a swap that involves an empty slot, changes nothing and raises `underflow` for one cycle.
- R6: `st0Data` shows st(0) and `stIData` shows st(`readIdx`) combinationally. `readUnderflow` is 1 whenever either of those two slots is empty.
- R7: Swap (`opCode` = 2'd3) exchanges st(0) and st(`opIdx`) in a single cycle.
- R8: A result write with `resPop` = 0 stores `resData` in st(`resIdx`), marks that slot occupied, and leaves the top pointer unchanged.
- R9: A result write with `resPop` = 1 stores into st(`resIdx`) and then pops, so the stored value appears at st(`resIdx`−1).
- R10: When any operand-port command and a result write arrive in the same cycle, the command takes effect first. The result is written at the next edge, into the physical slot that st(`resIdx`) named when it arrived.
- R11: The top pointer wraps modulo eight. Filling, draining and refilling the stack returns every operand at the depth its push order predicts.
- R12: A result write that asks to pop while st(0) was empty still stores the result, but does not pop, and raises `underflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 2 | 0 idle, 1 push, 2 pop, 3 swap |
| opIdx | input | 3 | Depth i used by swap |
| pushData | input | 80 | Operand to push |
| resValid | input | 1 | Result write strobe |
| resIdx | input | 3 | Depth the result replaces |
| resPop | input | 1 | Pop after the result write |
| resData | input | 80 | Result value |
| readIdx | input | 3 | Depth of the second read operand |
| st0Data | output | 80 | Current st(0) |
| stIData | output | 80 | Current st(readIdx) |
| readUnderflow | output | 1 | One of the two read slots is empty |
| stValid | output | 8 | Bit i is set when st(i) is occupied |
| overflow | output | 1 | Push rejected at the last edge |
| underflow | output | 1 | Empty slot used at the last edge |

## Verification
A push and an arriving arithmetic result can fall in the same cycle. The bench provokes this by building a two-deep stack and then presenting a push together with a result aimed at st(1). At the first edge it judges that the push is visible at once and the named operand, now at st(2), still holds its old value. After one idle edge it judges that the same slot holds the result and nothing else has moved. The other checks compare every depth against a bench-side stack model after each command.

// File: rtl/fpStackPkg.sv
package fpStackPkg;
  localparam int STK_DEPTH = 8;   // must stay a power of two: the pointer wraps by truncation
  localparam int STK_PTR_W = $clog2(STK_DEPTH);

  typedef logic [STK_PTR_W-1:0] stkPtrT;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_XCHG = 2'd3
  } stkOpT;

  // strobes from the control to the datapath, one cycle's worth
  typedef struct packed {
    logic   pushWr;
    stkPtrT pushAddr;
    logic   swapEn;
    stkPtrT swapAddr;
    logic   resWr;
    logic   resFromHold;
    stkPtrT resAddr;
    logic   holdCapture;
    logic   clrTop;
  } stkStrobeT;
endpackage

// File: rtl/fpStackCtrl.sv
module fpStackCtrl
  import fpStackPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  stkOpT                opCode,
  input  stkPtrT               opIdx,
  input  logic                 resValid,
  input  stkPtrT               resIdx,
  input  logic                 resPop,
  input  logic [STK_DEPTH-1:0] validPhys,
  output stkPtrT               top,
  output stkStrobeT            strobe,
  output logic                 overflow,
  output logic                 underflow
);
  stkPtrT topNext;
  stkPtrT pushDest;
  stkPtrT xchgAddr;
  stkPtrT holdAddr;
  logic   holdPending;
  logic   holdPendingNext;
  logic   holdPop;
  logic   applyPop;
  logic   opFire;
  logic   ovfNext;
  logic   unfNext;

  assign pushDest = top - 1'b1;
  assign xchgAddr = top + opIdx;
  assign opFire   = (opCode != OP_NONE);

  always_comb begin
    strobe          = '0;
    topNext         = top;
    ovfNext         = 1'b0;
    unfNext         = 1'b0;
    holdPendingNext = holdPending;
    applyPop        = 1'b0;
    unique case (opCode)
      OP_PUSH: begin
        if (validPhys[pushDest]) begin
          ovfNext = 1'b1;
        end else begin
          strobe.pushWr   = 1'b1;
          strobe.pushAddr = pushDest;
          topNext         = pushDest;
        end
      end
      OP_POP: begin
        if (!validPhys[top]) begin
          unfNext = 1'b1;
        end else begin
          strobe.clrTop = 1'b1;
          topNext       = top + 1'b1;
        end
      end
      OP_XCHG: begin
        if (!validPhys[top] || !validPhys[xchgAddr]) begin
          unfNext = 1'b1;
        end else begin
          strobe.swapEn   = 1'b1;
          strobe.swapAddr = xchgAddr;
        end
      end
      default: ;
    endcase
    if (opFire) begin
      if (resValid) begin
        strobe.holdCapture = 1'b1;
        holdPendingNext    = 1'b1;
      end
    end else if (holdPending || resValid) begin
      strobe.resWr       = 1'b1;
      strobe.resFromHold = holdPending;
      strobe.resAddr     = holdPending ? holdAddr : stkPtrT'(top + resIdx);
      applyPop           = holdPending ? holdPop : resPop;
      holdPendingNext    = 1'b0;
      if (applyPop) begin
        if (validPhys[top]) begin
          strobe.clrTop = 1'b1;
          topNext       = top + 1'b1;
        end else begin
          unfNext = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      top         <= '0;
      holdPending <= 1'b0;
      holdAddr    <= '0;
      holdPop     <= 1'b0;
      overflow    <= 1'b0;
      underflow   <= 1'b0;
    end else begin
      top         <= topNext;
      holdPending <= holdPendingNext;
      overflow    <= ovfNext;
      underflow   <= unfNext;
      if (strobe.holdCapture) begin
        holdAddr <= top + resIdx;
        holdPop  <= resPop;
      end
    end
  end

  // R3: a push onto a full stack keeps the pointer and flags overflow
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_PUSH && validPhys[top - 1'b1]) |=> (overflow && top == $past(top)));

  // R5: a pop of an empty top keeps the pointer and flags underflow
  a_r5_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_POP && !validPhys[top]) |=> (underflow && top == $past(top)));

  // R10: a result that meets an operand command is parked
  a_r10_defer: assert property (@(posedge clk) disable iff (!rstN)
    (opFire && resValid) |=> holdPending);
endmodule

// File: rtl/fpStackData.sv
module fpStackData
  import fpStackPkg::*;
#(
  parameter int WIDTH = 80
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stkStrobeT            strobe,
  input  stkPtrT               top,
  input  stkPtrT               readIdx,
  input  logic [WIDTH-1:0]     pushData,
  input  logic [WIDTH-1:0]     resData,
  output logic [STK_DEPTH-1:0] validPhys,
  output logic [WIDTH-1:0]     st0Data,
  output logic [WIDTH-1:0]     stIData,
  output logic                 readUnderflow,
  output logic [STK_DEPTH-1:0] stValid
);
  logic [WIDTH-1:0] mem [STK_DEPTH];
  logic [WIDTH-1:0] holdData;
  stkPtrT           rdAddr;

  assign rdAddr = top + readIdx;

  always_ff @(posedge clk) begin
    if (strobe.pushWr) mem[strobe.pushAddr] <= pushData;
    if (strobe.swapEn) begin
      mem[top]             <= mem[strobe.swapAddr];
      mem[strobe.swapAddr] <= mem[top];
    end
    if (strobe.resWr) mem[strobe.resAddr] <= strobe.resFromHold ? holdData : resData;
    if (strobe.holdCapture) holdData <= resData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validPhys <= '0;
    end else begin
      if (strobe.pushWr) validPhys[strobe.pushAddr] <= 1'b1;
      if (strobe.resWr)  validPhys[strobe.resAddr]  <= 1'b1;
      if (strobe.clrTop) validPhys[top]             <= 1'b0;
    end
  end

  assign st0Data       = mem[top];
  assign stIData       = mem[rdAddr];
  assign readUnderflow = !validPhys[top] || !validPhys[rdAddr];

  for (genvar d = 0; d < STK_DEPTH; d++) begin : g_relTag
    assign stValid[d] = validPhys[stkPtrT'(top + stkPtrT'(d))];
  end

  // R2: a pushed slot is occupied after the edge
  a_r2_push_marks: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushWr |=> validPhys[$past(strobe.pushAddr)]);

  // R7: swap moves the named operand to the top slot
  a_r7_swap_moves: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swapEn |=> mem[$past(top)] == $past(mem[strobe.swapAddr]));

  // R4: the popped slot is empty after the edge
  a_r4_pop_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrTop |=> !validPhys[$past(top)]);
endmodule

// File: rtl/fpStack.sv
module fpStack
  import fpStackPkg::*;
#(
  parameter int WIDTH = 80
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           opCode,
  input  logic [STK_PTR_W-1:0] opIdx,
  input  logic [WIDTH-1:0]     pushData,
  input  logic                 resValid,
  input  logic [STK_PTR_W-1:0] resIdx,
  input  logic                 resPop,
  input  logic [WIDTH-1:0]     resData,
  input  logic [STK_PTR_W-1:0] readIdx,
  output logic [WIDTH-1:0]     st0Data,
  output logic [WIDTH-1:0]     stIData,
  output logic                 readUnderflow,
  output logic [STK_DEPTH-1:0] stValid,
  output logic                 overflow,
  output logic                 underflow
);
  stkStrobeT            strobe;
  stkPtrT               top;
  logic [STK_DEPTH-1:0] validPhys;

  fpStackCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opCode    (stkOpT'(opCode)),
    .opIdx     (opIdx),
    .resValid  (resValid),
    .resIdx    (resIdx),
    .resPop    (resPop),
    .validPhys (validPhys),
    .top       (top),
    .strobe    (strobe),
    .overflow  (overflow),
    .underflow (underflow)
  );

  fpStackData #(.WIDTH(WIDTH)) i_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .top           (top),
    .readIdx       (readIdx),
    .pushData      (pushData),
    .resData       (resData),
    .validPhys     (validPhys),
    .st0Data       (st0Data),
    .stIData       (stIData),
    .readUnderflow (readUnderflow),
    .stValid       (stValid)
  );
endmodule

// File: tb/test_fpStack.sv
`timescale 1ns/1ps
module test_fpStack;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opCode = 2'd0;
  logic [2:0]  opIdx = 3'd0;
  logic [79:0] pushData = '0;
  logic        resValid = 1'b0;
  logic [2:0]  resIdx = 3'd0;
  logic        resPop = 1'b0;
  logic [79:0] resData = '0;
  logic [2:0]  readIdx = 3'd0;
  logic [79:0] st0Data, stIData;
  logic        readUnderflow, overflow, underflow;
  logic [7:0]  stValid;

  int checks = 0;
  int errors = 0;

  logic [79:0] mdl [8];
  logic        mv  [8];

  fpStack i_fpStack (
    .clk(clk), .rstN(rstN), .opCode(opCode), .opIdx(opIdx), .pushData(pushData),
    .resValid(resValid), .resIdx(resIdx), .resPop(resPop), .resData(resData),
    .readIdx(readIdx), .st0Data(st0Data), .stIData(stIData),
    .readUnderflow(readUnderflow), .stValid(stValid),
    .overflow(overflow), .underflow(underflow)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void mPush(logic [79:0] d);
    for (int i = 7; i > 0; i--) begin
      mdl[i] = mdl[i-1];
      mv[i]  = mv[i-1];
    end
    mdl[0] = d;
    mv[0]  = 1'b1;
  endfunction

  function automatic void mPop();
    for (int i = 0; i < 7; i++) begin
      mdl[i] = mdl[i+1];
      mv[i]  = mv[i+1];
    end
    mv[7] = 1'b0;
  endfunction

  // compare every depth against the model
  task automatic checkStack(string req);
    for (int i = 0; i < 8; i++) begin
      readIdx = 3'(i);
      #1;
      check(req, 80'(stValid[i]), 80'(mv[i]));
      if (mv[i]) check(req, stIData, mdl[i]);
    end
    readIdx = 3'd0;
  endtask

  // present inputs at a falling edge, hold them over one rising edge
  task automatic step(string req, logic [1:0] op, logic [2:0] idx, logic [79:0] d,
                      logic rv, logic [2:0] ri, logic rp, logic [79:0] rd,
                      logic expOvf, logic expUnf);
    opCode = op; opIdx = idx; pushData = d;
    resValid = rv; resIdx = ri; resPop = rp; resData = rd;
    @(negedge clk);
    opCode = 2'd0; resValid = 1'b0; resPop = 1'b0;
    check({req, " overflow"}, 80'(overflow), 80'(expOvf));
    check({req, " underflow"}, 80'(underflow), 80'(expUnf));
  endtask

  task automatic doPush(string req, logic [79:0] d, logic expOvf);
    step(req, 2'd1, 3'd0, d, 1'b0, 3'd0, 1'b0, '0, expOvf, 1'b0);
    if (!expOvf) mPush(d);
  endtask

  task automatic testReset();
    check("R1 valid", 80'(stValid), 80'h0);
    check("R1 overflow", 80'(overflow), 80'h0);
    check("R1 underflow", 80'(underflow), 80'h0);
    check("R1 readUnderflow", 80'(readUnderflow), 80'h1);
  endtask

  task automatic testPushRead();
    doPush("R2", 80'hA, 1'b0);
    doPush("R2", 80'hB, 1'b0);
    doPush("R2", 80'hC, 1'b0);
    checkStack("R2");
    readIdx = 3'd2; #1;
    check("R6 st0", st0Data, 80'hC);
    check("R6 stI", stIData, 80'hA);
    check("R6 readUnderflow", 80'(readUnderflow), 80'h0);
    readIdx = 3'd5; #1;
    check("R6 empty read", 80'(readUnderflow), 80'h1);
    readIdx = 3'd0;
  endtask

  task automatic testSwap();
    logic [79:0] t;
    step("R7", 2'd3, 3'd2, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b0);
    t = mdl[0]; mdl[0] = mdl[2]; mdl[2] = t;
    checkStack("R7");
    step("R5 swap empty", 2'd3, 3'd4, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b1);
    checkStack("R5 swap empty");
  endtask

  task automatic testResult();
    step("R8", 2'd0, 3'd0, '0, 1'b1, 3'd1, 1'b0, 80'hD, 1'b0, 1'b0);
    mdl[1] = 80'hD;
    checkStack("R8");
    step("R9", 2'd0, 3'd1, '0, 1'b1, 3'd1, 1'b1, 80'hE, 1'b0, 1'b0);
    mdl[1] = 80'hE; mPop();
    checkStack("R9");
    check("R9 st0", st0Data, 80'hE);
  endtask

  task automatic testPopEmpty();
    while (mv[0]) begin
      check("R4 popped value", st0Data, mdl[0]);
      step("R4", 2'd2, 3'd0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b0);
      mPop();
      checkStack("R4");
    end
    step("R5 pop empty", 2'd2, 3'd0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b1);
    checkStack("R5 pop empty");
    step("R12", 2'd0, 3'd0, '0, 1'b1, 3'd0, 1'b1, 80'h12, 1'b0, 1'b1);
    mdl[0] = 80'h12; mv[0] = 1'b1;
    checkStack("R12");
  endtask

  task automatic testFullWrap();
    for (int i = 0; i < 7; i++) doPush("R11", 80'(64'h100 + i), 1'b0);
    checkStack("R11 full");
    doPush("R3", 80'hFF, 1'b1);
    checkStack("R3 unchanged");
    step("R3 pulse", 2'd0, 3'd0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step("R11 drain", 2'd2, 3'd0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b0);
      mPop();
    end
    for (int i = 0; i < 5; i++) doPush("R11 refill", 80'(64'h200 + i), 1'b0);
    checkStack("R11 refill");
    for (int i = 0; i < 5; i++) begin
      step("R11 drain", 2'd2, 3'd0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b0);
      mPop();
    end
    checkStack("R11 empty");
  endtask

  task automatic testConflict();
    doPush("R10 setup", 80'h51, 1'b0);
    doPush("R10 setup", 80'h52, 1'b0);
    step("R10", 2'd1, 3'd0, 80'h53, 1'b1, 3'd1, 1'b0, 80'h77, 1'b0, 1'b0);
    mPush(80'h53);
    checkStack("R10 push first");
    step("R10 late", 2'd0, 3'd0, '0, 1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b0);
    mdl[2] = 80'h77;
    checkStack("R10 late write");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      mdl[i] = '0;
      mv[i]  = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPushRead();
    testSwap();
    testResult();
    testPopEmpty();
    testFullWrap();
    testConflict();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule